// File: doc/BRIEF.md
# Strobed Byte-Bus Register Bridge

This block lets a USB peripheral controller reach a small on-chip memory over a byte-wide, bidirectional bus. The controller runs a parallel-port style handshake: it pulls an address strobe or a data strobe low, sets a direction pin, and waits for the bridge to raise a wait/acknowledge line before it lets the strobe go. There are four kinds of transfer. Address write and address read reach a pointer register. Data write and data read reach a 256-byte RAM at the location held in that pointer.

After every data access the pointer steps forward by one. A host can therefore stream a whole block of bytes after a single address cycle. The bridge runs in the interface clock domain. It re-times the strobe and direction pins through a two-stage synchronizer before its state machine acts on them. It drives the shared bus only during the output phase of a read cycle.

Top module: `sbb_bridge`

## Requirements
- R1: After synchronous reset, `hs_wait` is 0, the bus is released (high impedance), and the pointer register holds 0x00.
- R2: An address cycle (`adr_stb_n` low, `to_host` = 0) loads the byte on `host_bus` into the pointer register.
- R3: An address cycle with `to_host` = 1 drives the pointer register value onto `host_bus` while `hs_wait` is high.
- R4: A data cycle with `to_host` = 0 stores the bus byte into RAM at the pointer. A data cycle with `to_host` = 1 returns the RAM byte at the pointer on `host_bus` while `hs_wait` is high.
- R5: After every data cycle, in either direction, the pointer is one greater than before. Address cycles never step it.
- R6: Stepping the pointer from 0xFF gives 0x00.
- R7: `host_bus` is driven only while `to_host` = 1 and a read cycle is in its output phase. At all other times it is high impedance, including mid-cycle when `to_host` is dropped.
- R8: `hs_wait` rises on the fourth rising clock edge after a strobe falls. It falls on the third rising edge after that strobe is released.
- R9: When both strobes fall together while the bridge is idle, the address cycle wins. The pointer is loaded and the RAM is not written.
- R10: A strobe that arrives while another cycle is in progress is ignored. The running cycle keeps `hs_wait` high and the pointer unchanged until its own strobe is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_stb_n | input | 1 | Address strobe, active low |
| dat_stb_n | input | 1 | Data strobe, active low |
| to_host | input | 1 | Direction: 1 = bridge drives the bus, 0 = host drives it |
| host_bus | inout | DATA_W (8) | Shared tri-state byte bus |
| hs_wait | output | 1 | High when the current transfer may be completed |

## Verification
The bench streams bytes across the top of the pointer range. A bridge that failed to wrap, or that stepped on address cycles, would return the wrong bytes or a wrong pointer readback. It raises both strobes at once and expects the address load. A bridge with the wrong priority would corrupt a RAM byte and keep the old pointer. It also asserts a second strobe in the middle of a running data write and drops the direction pin during a read's output phase. A bridge that abandoned the cycle or kept driving the bus would show a changed pointer or a driven value where the pulled-up idle level is expected. Every cycle is timed edge by edge, so an extra or missing synchronizer stage shows up as a shifted `hs_wait`.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  // Cycle sequencer states: one idle state plus a setup and a hold stage
  // for each of the four transfer kinds.
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_AW_SET  = 4'd1,
    ST_AW_HOLD = 4'd2,
    ST_AR_SET  = 4'd3,
    ST_AR_HOLD = 4'd4,
    ST_DW_SET  = 4'd5,
    ST_DW_HOLD = 4'd6,
    ST_DR_SET  = 4'd7,
    ST_DR_HOLD = 4'd8
  } sbb_state_e;

  // Control word produced by the sequencer, one field per datapath enable.
  typedef struct packed {
    logic ld_addr;   // pointer takes the bus byte
    logic ram_wr;    // RAM write at pointer
    logic ram_rd;    // registered RAM read at pointer
    logic drive;     // output phase of a read
    logic sel_data;  // 1: RAM byte on bus, 0: pointer on bus
    logic ready;     // handshake acknowledge
  } sbb_ctrl_t;

  function automatic sbb_ctrl_t ctrl_of(sbb_state_e s);
    sbb_ctrl_t c;
    c = '0;
    case (s)
      ST_AW_SET:  c.ld_addr = 1'b1;
      ST_AW_HOLD: c.ready   = 1'b1;
      ST_AR_SET:  c.drive   = 1'b1;
      ST_AR_HOLD: begin
        c.drive = 1'b1;
        c.ready = 1'b1;
      end
      ST_DW_SET:  c.ram_wr  = 1'b1;
      ST_DW_HOLD: c.ready   = 1'b1;
      ST_DR_SET:  c.ram_rd  = 1'b1;
      ST_DR_HOLD: begin
        c.drive    = 1'b1;
        c.sel_data = 1'b1;
        c.ready    = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sbb_sync.sv
module sbb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sbb_fsm.sv
module sbb_fsm
  import sbb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      astb_s,
  input  logic      dstb_s,
  input  logic      dir_s,
  output sbb_ctrl_t ctrl_q
);

  sbb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        // Address strobe has priority when both arrive together.
        if (!astb_s)      state_d = dir_s ? ST_AR_SET : ST_AW_SET;
        else if (!dstb_s) state_d = dir_s ? ST_DR_SET : ST_DW_SET;
      end
      ST_AW_SET:  state_d = ST_AW_HOLD;
      ST_AR_SET:  state_d = ST_AR_HOLD;
      ST_DW_SET:  state_d = ST_DW_HOLD;
      ST_DR_SET:  state_d = ST_DR_HOLD;
      ST_AW_HOLD,
      ST_AR_HOLD: if (astb_s) state_d = ST_IDLE;
      ST_DW_HOLD,
      ST_DR_HOLD: if (dstb_s) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Controls are registered from the next state so they line up with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_of(state_d);
    end
  end

endmodule

// File: rtl/sbb_ram.sv
module sbb_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end

endmodule

// File: rtl/sbb_datapath.sv
module sbb_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr,
  input  logic              ram_wr,
  input  logic              ram_rd,
  input  logic              sel_data,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] out_byte
);

  logic [DATA_W-1:0] rd_byte;

  // Pointer: a load beats the post-access step; the step wraps naturally.
  always_ff @(posedge clk) begin
    if (rst)                  addr_q <= '0;
    else if (ld_addr)         addr_q <= bus_in[ADDR_W-1:0];
    else if (ram_wr || ram_rd) addr_q <= addr_q + 1'b1;
  end

  sbb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_wr),
    .re    (ram_rd),
    .addr  (addr_q),
    .wdata (bus_in),
    .rdata (rd_byte)
  );

  assign out_byte = sel_data ? rd_byte : DATA_W'(addr_q);

endmodule

// File: rtl/sbb_bridge.sv
module sbb_bridge
  import sbb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adr_stb_n,
  input  logic              dat_stb_n,
  input  logic              to_host,
  inout  wire  [DATA_W-1:0] host_bus,
  output logic              hs_wait
);

  logic [2:0]        pins_s;
  logic              astb_s, dstb_s, dir_s;
  sbb_ctrl_t         ctrl;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] out_byte;
  logic [DATA_W-1:0] bus_in;

  sbb_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({adr_stb_n, dat_stb_n, to_host}),
    .q   (pins_s)
  );

  assign {astb_s, dstb_s, dir_s} = pins_s;

  sbb_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .astb_s (astb_s),
    .dstb_s (dstb_s),
    .dir_s  (dir_s),
    .ctrl_q (ctrl)
  );

  assign bus_in = host_bus;

  sbb_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ld_addr  (ctrl.ld_addr),
    .ram_wr   (ctrl.ram_wr),
    .ram_rd   (ctrl.ram_rd),
    .sel_data (ctrl.sel_data),
    .bus_in   (bus_in),
    .addr_q   (addr_q),
    .out_byte (out_byte)
  );

  assign host_bus = (ctrl.drive && to_host) ? out_byte : {DATA_W{1'bz}};
  assign hs_wait  = ctrl.ready;

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_addr,
  input logic              ram_wr,
  input logic              ram_rd,
  input logic              hs_wait,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] bus_in
);

  // R5 and R6: one step after each RAM access, wrapping at the top.
  a_r5_step_after_access: assert property (@(posedge clk) disable iff (rst)
    (ram_wr || ram_rd) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  // R2: pointer load takes the byte present on the bus.
  a_r2_load_from_bus: assert property (@(posedge clk) disable iff (rst)
    ld_addr |=> (addr_q == ADDR_W'($past(bus_in))));

  // R9: never two datapath actions in one cycle.
  a_r9_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_addr, ram_wr, ram_rd}));

  // R10: pointer frozen while a cycle holds its acknowledge.
  a_r10_hold_freezes_ptr: assert property (@(posedge clk) disable iff (rst)
    (hs_wait && $past(hs_wait)) |-> $stable(addr_q));

  // R8: acknowledge never overlaps a datapath action.
  a_r8_ack_after_action: assert property (@(posedge clk) disable iff (rst)
    hs_wait |-> !(ld_addr || ram_wr || ram_rd));

endmodule

bind sbb_bridge sbb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ld_addr (ctrl.ld_addr),
  .ram_wr  (ctrl.ram_wr),
  .ram_rd  (ctrl.ram_rd),
  .hs_wait (hs_wait),
  .addr_q  (addr_q),
  .bus_in  (bus_in)
);

// File: tb/sbb_bridge_test.sv
module sbb_bridge_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adr_stb_n = 1'b1;
  logic dat_stb_n = 1'b1;
  logic to_host = 1'b0;
  logic host_en = 1'b0;
  logic [7:0] host_val = 8'h00;
  tri1 [7:0] host_bus;
  wire hs_wait;

  assign host_bus = host_en ? host_val : 8'hzz;

  always #2 clk = ~clk;

  sbb_bridge uut (
    .clk       (clk),
    .rst       (rst),
    .adr_stb_n (adr_stb_n),
    .dat_stb_n (dat_stb_n),
    .to_host   (to_host),
    .host_bus  (host_bus),
    .hs_wait   (hs_wait)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  exp_t       e;
  int         checks = 0;
  int         fails  = 0;
  logic [7:0] mem_m [256];
  logic [7:0] m_addr = 8'h00;
  logic       seen = 1'b0;

  function automatic void check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endfunction

  // Monitor: on each acknowledge rise of a bridge-driven cycle, pop and compare.
  always @(negedge clk) begin
    if (hs_wait && !seen && to_host) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", host_bus, 8'h00);
      end else begin
        e = exp_q.pop_front();
        check(host_bus == e.val, e.tag, host_bus, e.val);
      end
    end
    seen = hs_wait;
  end

  task automatic wait_level(logic lvl, string tag);
    int n = 0;
    while (hs_wait !== lvl && n < 64) begin
      @(negedge clk);
      n++;
    end
    check(hs_wait == lvl, tag, {7'b0, hs_wait}, {7'b0, lvl});
  endtask

  // One complete handshake, with edge-exact acknowledge timing (R8).
  task automatic host_cycle(bit is_addr, bit dir, logic [7:0] val);
    @(negedge clk);
    to_host  = dir;
    host_en  = !dir;
    host_val = val;
    @(negedge clk);
    if (is_addr) adr_stb_n = 1'b0; else dat_stb_n = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(hs_wait == (k == 4), "R8 rise", {7'b0, hs_wait}, {7'b0, k == 4});
    end
    if (is_addr) adr_stb_n = 1'b1; else dat_stb_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(hs_wait == (k < 3), "R8 fall", {7'b0, hs_wait}, {7'b0, k < 3});
    end
    host_en = 1'b0;
    to_host = 1'b0;
  endtask

  task automatic set_addr(logic [7:0] v);
    host_cycle(1'b1, 1'b0, v);
    m_addr = v;
  endtask

  task automatic get_addr(string tag);
    exp_q.push_back('{m_addr, tag});
    host_cycle(1'b1, 1'b1, 8'h00);
  endtask

  task automatic wr_byte(logic [7:0] v);
    mem_m[m_addr] = v;
    m_addr = m_addr + 8'd1;
    host_cycle(1'b0, 1'b0, v);
  endtask

  task automatic rd_byte(string tag);
    exp_q.push_back('{mem_m[m_addr], tag});
    m_addr = m_addr + 8'd1;
    host_cycle(1'b0, 1'b1, 8'h00);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(hs_wait == 1'b0, "R1 wait", {7'b0, hs_wait}, 8'h00);
    to_host = 1'b1;
    @(negedge clk);
    check(host_bus == 8'hFF, "R1/R7 idle bus released", host_bus, 8'hFF);
    to_host = 1'b0;
    get_addr("R1 pointer");

    // R2, R3: pointer load and readback
    set_addr(8'h05);
    get_addr("R2/R3 pointer");

    // R4, R5: block write then block read with one address cycle each
    wr_byte(8'hA1);
    wr_byte(8'hB2);
    wr_byte(8'hC3);
    wr_byte(8'hD4);
    get_addr("R5 after writes");
    set_addr(8'h05);
    for (int i = 0; i < 4; i++) rd_byte("R4 read");
    get_addr("R5 after reads");

    // R6: wrap at the top of the range
    set_addr(8'hFE);
    wr_byte(8'h11);
    wr_byte(8'h22);
    wr_byte(8'h33);
    get_addr("R6 wrapped pointer");
    set_addr(8'hFF);
    rd_byte("R6 read FF");
    rd_byte("R6 read 00");

    // R9: both strobes at once, address wins, RAM untouched
    set_addr(8'h10);
    wr_byte(8'h3C);
    set_addr(8'h10);
    @(negedge clk);
    to_host = 1'b0; host_en = 1'b1; host_val = 8'h55;
    @(negedge clk);
    adr_stb_n = 1'b0; dat_stb_n = 1'b0;
    wait_level(1'b1, "R9 ack");
    adr_stb_n = 1'b1; dat_stb_n = 1'b1;
    wait_level(1'b0, "R9 release");
    host_en = 1'b0;
    m_addr = 8'h55;
    get_addr("R9 pointer loaded");
    set_addr(8'h10);
    rd_byte("R9 RAM untouched");

    // R10: address strobe during a running data write is ignored
    set_addr(8'h20);
    @(negedge clk);
    to_host = 1'b0; host_en = 1'b1; host_val = 8'h77;
    @(negedge clk);
    dat_stb_n = 1'b0;
    wait_level(1'b1, "R10 ack");
    adr_stb_n = 1'b0;
    repeat (6) @(negedge clk);
    check(hs_wait == 1'b1, "R10 cycle held", {7'b0, hs_wait}, 8'h01);
    adr_stb_n = 1'b1;
    repeat (4) @(negedge clk);
    dat_stb_n = 1'b1;
    wait_level(1'b0, "R10 release");
    host_en = 1'b0;
    mem_m[8'h20] = 8'h77;
    m_addr = 8'h21;
    get_addr("R10 pointer unchanged by stray strobe");

    // R7: dropping direction mid-read releases the bus at once
    set_addr(8'h20);
    exp_q.push_back('{8'h77, "R4 read in R7 cycle"});
    @(negedge clk);
    to_host = 1'b1;
    @(negedge clk);
    dat_stb_n = 1'b0;
    wait_level(1'b1, "R7 ack");
    @(negedge clk);
    to_host = 1'b0;
    #1;
    check(host_bus == 8'hFF, "R7 released", host_bus, 8'hFF);
    to_host = 1'b1;
    #1;
    check(host_bus == 8'h77, "R7 driven again", host_bus, 8'h77);
    dat_stb_n = 1'b1;
    wait_level(1'b0, "R7 release");
    to_host = 1'b0;
    m_addr = 8'h21;
    get_addr("R5 after single read");

    check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h01, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule